// File: doc/BRIEF.md
# Keyed Clock-Gating Request Controller

This block keeps one clock-gating request per accelerator engine and turns each request into the signals that drive that engine's clock gate. Software writes two 32-bit registers: a mode register and a request register. The mode register chooses, per engine, how the gate is driven. A direct engine has its clock enable follow its request bit. A handshaked engine is asked to go idle first and has its clock stopped only after it acknowledges.

A write to the request register carries a 4-bit key in its top nibble. One key turns the write into an atomic set of request bits and another into an atomic clear, so separate software agents can change their own engines without a read-modify-write race. Any other key stores the low bits as written. A per-engine status output reports when an engine's clock is fully running with no handshake in progress.

Top module: `cg_request_ctrl`

## Requirements
- R1: After synchronous reset, the mode and request registers are all zero, and every clk_en, idle_req and clk_running output is 0.
- R2: A write to the request register (wr_sel=1) with wr_data[31:28]=4'h5 sets each request bit whose data bit in [N_ENG-1:0] is 1 and leaves the others unchanged.
- R3: A write to the request register with wr_data[31:28]=4'h2 clears each request bit whose data bit is 1 and leaves the others unchanged.
- R4: A request-register write with any other key stores wr_data[N_ENG-1:0] as written. A read of either register (rd_sel=1 request, rd_sel=0 mode) returns its bits in [N_ENG-1:0] and zeros in every higher bit, so the key never reads back.
- R5: A write to the mode register (wr_sel=0) always stores wr_data[N_ENG-1:0] as written, whatever the top nibble holds. Mode bit 1 selects the handshake protocol and 0 selects direct.
- R6: For a direct-mode engine, clk_en equals the request bit of the previous cycle, and idle_req stays 0.
- R7: For a handshake engine whose clock is running, clearing its request raises idle_req one cycle later. clk_en stays 1 until idle_ack is sampled high, and drops in the following cycle.
- R8: For a gated handshake engine, setting its request raises clk_en one cycle later while idle_req is still 1. idle_req falls one cycle after that.
- R9: If a handshake engine's request is set again while the engine waits for idle_ack, the engine returns to running in the next cycle. idle_req falls and clk_en never drops.
- R10: clk_running is 1 only when the engine's clock is enabled and no idle request is pending. It is 1 one cycle after ungate in direct mode and two cycles after ungate in handshake mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode register, 1 request register |
| wr_data | input | 32 | Write data; key in [31:28] for request writes |
| rd_sel | input | 1 | Read target: 0 mode register, 1 request register |
| rd_data | output | 32 | Combinational read data |
| idle_ack | input | N_ENG | Per-engine idle acknowledge |
| clk_en | output | N_ENG | Per-engine clock enable toward the gate cell |
| idle_req | output | N_ENG | Per-engine idle request |
| clk_running | output | N_ENG | Per-engine status: clock running, no handshake pending |

## Verification
The bench builds the block with its default parameters: five engines on a 32-bit data word. This width leaves 23 bits between the request field and the key, so the bench can check that random upper bits never read back. The random phase keeps every engine in direct mode and mixes set, clear and plain keys with random masks. This reaches overlapping set and clear patterns across all five engines. Directed sequences then move one engine to handshake mode to reach the idle wait, a slow acknowledge, and a request that comes back during the wait.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam int KEY_W = 4;
    localparam logic [KEY_W-1:0] KEY_SET = 4'h5;
    localparam logic [KEY_W-1:0] KEY_CLR = 4'h2;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_WAKE  = 2'd1,
        CH_ON    = 2'd2,
        CH_DRAIN = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        WR_SET,
        WR_CLR,
        WR_PLAIN
    } wr_kind_e;

    function automatic wr_kind_e decode_key(input logic [KEY_W-1:0] key);
        if (key == KEY_SET) return WR_SET;
        if (key == KEY_CLR) return WR_CLR;
        return WR_PLAIN;
    endfunction

endpackage

// File: rtl/cgr_regs.sv
module cgr_regs
    import cgr_pkg::*;
#(
    parameter int N_ENG  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_ENG-1:0]  mode_q,
    output logic [N_ENG-1:0]  req_q
);
    localparam int KEY_LSB = DATA_W - KEY_W;
    localparam int PAD_W   = DATA_W - N_ENG;

    logic [KEY_W-1:0] key;
    logic [N_ENG-1:0] bits;
    logic [N_ENG-1:0] req_nxt;
    wr_kind_e         kind;

    assign key  = wr_data[DATA_W-1:KEY_LSB];
    assign bits = wr_data[N_ENG-1:0];
    assign kind = decode_key(key);

    always_comb begin
        unique case (kind)
            WR_SET:  req_nxt = req_q | bits;
            WR_CLR:  req_nxt = req_q & ~bits;
            default: req_nxt = bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            req_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) req_q  <= req_nxt;
            else        mode_q <= bits;
        end
    end

    assign rd_data = {{PAD_W{1'b0}}, (rd_sel ? req_q : mode_q)};

endmodule

// File: rtl/cgr_channel.sv
module cgr_channel
    import cgr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_hs,
    input  logic req,
    input  logic idle_ack,
    output logic clk_en,
    output logic idle_req,
    output logic running
);
    ch_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        if (!mode_hs) begin
            state_nxt = req ? CH_ON : CH_OFF;
        end else begin
            unique case (state)
                CH_OFF:   if (req) state_nxt = CH_WAKE;
                CH_WAKE:  state_nxt = CH_ON;
                CH_ON:    if (!req) state_nxt = CH_DRAIN;
                CH_DRAIN: begin
                    if (req)           state_nxt = CH_ON;
                    else if (idle_ack) state_nxt = CH_OFF;
                end
                default:  state_nxt = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CH_OFF;
        else     state <= state_nxt;
    end

    assign clk_en   = (state != CH_OFF);
    assign idle_req = mode_hs && (state != CH_ON);
    assign running  = (state == CH_ON);

endmodule

// File: rtl/cg_request_ctrl.sv
module cg_request_ctrl #(
    parameter int N_ENG  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_ENG-1:0]  idle_ack,
    output logic [N_ENG-1:0]  clk_en,
    output logic [N_ENG-1:0]  idle_req,
    output logic [N_ENG-1:0]  clk_running
);
    logic [N_ENG-1:0] mode_q;
    logic [N_ENG-1:0] req_q;

    cgr_regs #(.N_ENG(N_ENG), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .mode_q  (mode_q),
        .req_q   (req_q)
    );

    for (genvar e = 0; e < N_ENG; e++) begin : g_ch
        cgr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .mode_hs  (mode_q[e]),
            .req      (req_q[e]),
            .idle_ack (idle_ack[e]),
            .clk_en   (clk_en[e]),
            .idle_req (idle_req[e]),
            .running  (clk_running[e])
        );
    end

endmodule

// File: rtl/cgr_checker.sv
module cgr_checker #(
    parameter int N_ENG  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] rd_data,
    input logic [N_ENG-1:0]  mode_q,
    input logic [N_ENG-1:0]  req_q,
    input logic [N_ENG-1:0]  idle_ack,
    input logic [N_ENG-1:0]  clk_en,
    input logic [N_ENG-1:0]  idle_req,
    input logic [N_ENG-1:0]  clk_running
);
    // R1: the cycle after reset everything is cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (req_q == '0 && mode_q == '0 && clk_en == '0));

    // R4: bits above the request field never read back
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:N_ENG] == '0);

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        // R6: direct engine enable follows previous request
        a_r6_direct_follow: assert property (@(posedge clk) disable iff (rst)
            !$past(mode_q[e]) |-> (clk_en[e] == $past(req_q[e])));

        // R7: clock held while idle request waits without acknowledge
        a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
            $past(mode_q[e] && clk_en[e] && idle_req[e] && !idle_ack[e]) |-> clk_en[e]);

        // R8: idle request released only with clock enabled
        a_r8_release_enabled: assert property (@(posedge clk) disable iff (rst)
            (mode_q[e] && $past(mode_q[e]) && $fell(idle_req[e])) |-> clk_en[e]);

        // R10: running means enabled and no pending idle request
        a_r10_running: assert property (@(posedge clk) disable iff (rst)
            clk_running[e] |-> (clk_en[e] && !idle_req[e]));
    end
endmodule

bind cg_request_ctrl cgr_checker #(.N_ENG(N_ENG), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_data     (rd_data),
    .mode_q      (mode_q),
    .req_q       (req_q),
    .idle_ack    (idle_ack),
    .clk_en      (clk_en),
    .idle_req    (idle_req),
    .clk_running (clk_running)
);

// File: tb/sim_cg_request_ctrl.sv
`timescale 1ns/1ps
module sim_cg_request_ctrl;
    localparam int N  = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_sel = 1'b0;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  idle_ack = '0;
    logic [N-1:0]  clk_en, idle_req, clk_running;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_req = '0;
    logic [N-1:0] m_mode = '0;

    always #5 clk = ~clk;

    cg_request_ctrl #(.N_ENG(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .idle_ack(idle_ack),
        .clk_en(clk_en), .idle_req(idle_req), .clk_running(clk_running)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_req(input logic [N-1:0] cur, input logic [DW-1:0] d);
        logic [N-1:0] b = d[N-1:0];
        case (d[31:28])
            4'h5:    return cur | b;
            4'h2:    return cur & ~b;
            default: return b;
        endcase
    endfunction

    task automatic wr(input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_req = model_req(m_req, d);
        else     m_mode = d[N-1:0];
    endtask

    task automatic rd_check(input string tag, input logic sel, input logic [DW-1:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_check("R1 req", 1'b1, 32'h0);
        rd_check("R1 mode", 1'b0, 32'h0);
        chk("R1 clk_en", {27'd0, clk_en}, 32'h0);
        chk("R1 idle_req", {27'd0, idle_req}, 32'h0);
        chk("R1 running", {27'd0, clk_running}, 32'h0);

        // directed key writes
        wr(1'b1, 32'h5000_0005);
        rd_check("R2 set from zero", 1'b1, 32'h5);
        wr(1'b1, 32'h5FFF_FF02);
        rd_check("R2 set keeps zeros", 1'b1, 32'h7);
        wr(1'b1, 32'h2000_0004);
        rd_check("R3 clear one bit", 1'b1, 32'h3);
        wr(1'b1, 32'h2000_0000);
        rd_check("R3 clear with zero mask", 1'b1, 32'h3);
        wr(1'b1, 32'hA5A5_A5B8);
        rd_check("R4 plain write key hidden", 1'b1, 32'h18);
        wr(1'b1, 32'h0000_0000);
        rd_check("R4 plain write zero", 1'b1, 32'h0);
        step();
        chk("R6 enable off", {27'd0, clk_en}, 32'h0);

        // random phase, all engines direct
        for (int i = 0; i < 300; i++) begin
            int k = $urandom_range(0, 2);
            d = $urandom();
            if (k == 0)      d[31:28] = 4'h5;
            else if (k == 1) d[31:28] = 4'h2;
            wr(1'b1, d);
            rd_check(k == 0 ? "R2 random set" : (k == 1 ? "R3 random clear" : "R4 random write"),
                     1'b1, {27'd0, m_req});
            step();
            chk("R6 direct enable", {27'd0, clk_en}, {27'd0, m_req});
            chk("R6 no idle request", {27'd0, idle_req}, 32'h0);
            chk("R10 direct running", {27'd0, clk_running}, {27'd0, m_req});
        end

        // mode register ignores key
        wr(1'b0, 32'h5000_0003);
        rd_check("R5 mode plain with set key", 1'b0, 32'h3);
        wr(1'b0, 32'h2000_0001);
        rd_check("R5 mode plain with clear key", 1'b0, 32'h1);
        wr(1'b0, 32'hFFFF_FFE0);
        rd_check("R5 mode upper bits dropped", 1'b0, 32'h0);

        // handshake on engine 2, start gated
        wr(1'b1, 32'h0000_0000);
        step();
        wr(1'b0, 32'h0000_0004);
        chk("R8 gated holds idle_req", {31'd0, idle_req[2]}, 32'h1);
        wr(1'b1, 32'h5000_0004);
        chk("R8 not yet enabled", {31'd0, clk_en[2]}, 32'h0);
        step();
        chk("R8 enable first", {31'd0, clk_en[2]}, 32'h1);
        chk("R8 idle_req still high", {31'd0, idle_req[2]}, 32'h1);
        chk("R10 not running during wake", {31'd0, clk_running[2]}, 32'h0);
        step();
        chk("R8 idle_req released", {31'd0, idle_req[2]}, 32'h0);
        chk("R10 running after wake", {31'd0, clk_running[2]}, 32'h1);

        // gate with slow acknowledge
        wr(1'b1, 32'h2000_0004);
        chk("R7 still running at clear", {31'd0, idle_req[2]}, 32'h0);
        step();
        chk("R7 idle_req raised", {31'd0, idle_req[2]}, 32'h1);
        chk("R7 clock kept", {31'd0, clk_en[2]}, 32'h1);
        repeat (3) step();
        chk("R7 clock kept without ack", {31'd0, clk_en[2]}, 32'h1);
        idle_ack[2] = 1'b1;
        step();
        idle_ack[2] = 1'b0;
        chk("R7 clock stopped after ack", {31'd0, clk_en[2]}, 32'h0);
        chk("R7 idle_req held when gated", {31'd0, idle_req[2]}, 32'h1);

        // abort during drain
        wr(1'b1, 32'h5000_0004);
        step();
        step();
        chk("R10 running again", {31'd0, clk_running[2]}, 32'h1);
        wr(1'b1, 32'h2000_0004);
        step();
        chk("R9 draining", {31'd0, idle_req[2]}, 32'h1);
        wr(1'b1, 32'h5000_0004);
        chk("R9 still draining at set edge", {31'd0, idle_req[2]}, 32'h1);
        step();
        chk("R9 idle_req dropped", {31'd0, idle_req[2]}, 32'h0);
        chk("R9 clock never dropped", {31'd0, clk_en[2]}, 32'h1);
        chk("R9 running", {31'd0, clk_running[2]}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule